// File: doc/BRIEF.md
# Translation Cache with Walk Refill

The block is a small fully associative cache of page-to-frame mappings that sits in front of a page table walker. A requester presents a page number. Every stored entry is compared with it in the same cycle. When one matches, the frame number and its protection bits come back on the next cycle and the walker is left idle.

When no entry matches, the block sends the page to the walker and waits for the answer. A good answer is written into the cache and returned as the response in the same step. A faulting answer, such as a page beyond the table length, is returned with a fault flag and is never stored. The new mapping goes into the lowest-numbered empty entry. When every entry is full, a round-robin pointer picks the entry to evict. A one-cycle flush pulse empties the cache, for example on a process switch. Two free-running counters tally hits and misses, so the hit rate can be measured.

Top module: `tlb_walk_fill`

## Requirements
- R1: After reset every entry is empty, `req_ready` is 1, `rsp_valid` and `walk_req` are 0, and both counters read 0.
- R2: A request accepted (`req_valid` and `req_ready` both high) whose page matches a stored entry produces, on the next cycle, `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 and the stored frame and protection bits, with `walk_req` staying low.
- R3: A request accepted with no matching entry raises `walk_req` on the next cycle, with `walk_page` equal to the requested page. Both hold until `walk_done`, and `req_ready` stays 0 for as long as `walk_req` is high.
- R4: On the cycle after `walk_done` with `walk_fault`=0, the block gives `rsp_valid`=1, `rsp_hit`=0, `rsp_fault`=0, and the walker's frame and protection bits. A later request for the same page hits.
- R5: On the cycle after `walk_done` with `walk_fault`=1, the block gives `rsp_valid`=1 and `rsp_fault`=1, with frame and protection equal to 0. Nothing is stored, so a repeat of the request walks again.
- R6: A new mapping is written into the lowest-indexed empty entry when one exists.
- R7: When every entry is full, the victim is chosen by a round-robin pointer. The pointer is 0 after reset and moves to the next entry (wrapping at ENTRIES) after each eviction. A flush does not move it.
- R8: A flush pulse empties every entry within one cycle, so every following lookup misses until it is refilled.
- R9: `hit_count` increases by one for each accepted request that hits. `miss_count` increases by one for each accepted request that misses, including requests that end in a fault.
- R10: No page is ever stored in two valid entries at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | One-cycle pulse that empties all entries |
| req_valid | input | 1 | Lookup request present |
| req_page | input | PAGE_W | Page number to translate |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response came from a stored entry |
| rsp_fault | output | 1 | Walk reported a fault |
| rsp_frame | output | FRAME_W | Translated frame number |
| rsp_prot | output | PROT_W | Protection bits of the mapping |
| walk_req | output | 1 | Walk request, held until `walk_done` |
| walk_page | output | PAGE_W | Page number sent to the walker |
| walk_done | input | 1 | Walker result is valid this cycle |
| walk_frame | input | FRAME_W | Frame number from the walker |
| walk_prot | input | PROT_W | Protection bits from the walker |
| walk_fault | input | 1 | Walker reports out-of-bounds or invalid page |
| hit_count | output | CNT_W | Count of hits |
| miss_count | output | CNT_W | Count of misses |

## Verification
The assertions take for granted that `walk_done` arrives only while `walk_req` is high and lasts a single cycle. They also assume that a flush never falls in the same cycle as an accepted request, because a lookup in that cycle would still see the entries from before the flush. The stimulus keeps to both rules. The stub walker answers once, a fixed number of cycles after the request, and then waits for the next one. Flush pulses are applied only while the block is idle and no request is being driven.

// File: rtl/tlb_walk_fill.sv
module tlb_walk_fill #(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 16,
  parameter int PROT_W  = 3,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               req_valid,
  input  logic [PAGE_W-1:0]  req_page,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [PROT_W-1:0]  rsp_prot,
  output logic               walk_req,
  output logic [PAGE_W-1:0]  walk_page,
  input  logic               walk_done,
  input  logic [FRAME_W-1:0] walk_frame,
  input  logic [PROT_W-1:0]  walk_prot,
  input  logic               walk_fault,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [PAGE_W-1:0]  tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [PROT_W-1:0]  prot_q  [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic [IDX_W-1:0]   hit_idx, free_idx, rr, victim;
  logic               any_free, walking;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag_q[i] == req_page);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim    = any_free ? free_idx : rr;
  assign req_ready = !walking;
  assign walk_req  = walking;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld        <= '0;
      rr         <= '0;
      walking    <= 1'b0;
      walk_page  <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_frame  <= '0;
      rsp_prot   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
        prot_q[i]  <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      if (!walking && req_valid) begin
        if (|hit_vec) begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b1;
          rsp_fault <= 1'b0;
          rsp_frame <= frame_q[hit_idx];
          rsp_prot  <= prot_q[hit_idx];
          hit_count <= hit_count + 1'b1;
        end else begin
          walking    <= 1'b1;
          walk_page  <= req_page;
          miss_count <= miss_count + 1'b1;
        end
      end
      if (walking && walk_done) begin
        walking   <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b0;
        rsp_fault <= walk_fault;
        rsp_frame <= walk_fault ? '0 : walk_frame;
        rsp_prot  <= walk_fault ? '0 : walk_prot;
        if (!walk_fault && !flush) begin
          vld[victim]     <= 1'b1;
          tag_q[victim]   <= walk_page;
          frame_q[victim] <= walk_frame;
          prot_q[victim]  <= walk_prot;
          if (!any_free) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
        end
      end
      if (flush) vld <= '0;
    end
  end

  // R10
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  hit_no_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (|hit_vec) |=> rsp_valid && rsp_hit && !walk_req);

  // R3
  miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !(|hit_vec) |=> walk_req && walk_page == $past(req_page));

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_done |=> walk_req && $stable(walk_page));

  // R5
  fault_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && walk_done && walk_fault && !flush |=> vld == $past(vld));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vld == '0);

  // R4
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready) || $past(walk_req && walk_done));
endmodule

// File: tb/test_tlb_walk_fill.sv
module test_tlb_walk_fill;
  localparam int PAGE_W = 20, FRAME_W = 16, PROT_W = 3, CNT_W = 16;

  logic clk = 0, rst_n = 0, flush = 0, req_valid = 0;
  logic [PAGE_W-1:0] req_page = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, walk_req;
  logic [FRAME_W-1:0] rsp_frame;
  logic [PROT_W-1:0] rsp_prot;
  logic [PAGE_W-1:0] walk_page;
  logic walk_done = 0, walk_fault = 0;
  logic [FRAME_W-1:0] walk_frame = '0;
  logic [PROT_W-1:0] walk_prot = '0;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #2.5 clk = ~clk;

  tlb_walk_fill i_tlb_walk_fill (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_page(req_page),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_frame(rsp_frame), .rsp_prot(rsp_prot), .walk_req(walk_req), .walk_page(walk_page),
    .walk_done(walk_done), .walk_frame(walk_frame), .walk_prot(walk_prot),
    .walk_fault(walk_fault), .hit_count(hit_count), .miss_count(miss_count));

  int checks = 0, failures = 0, exp_hits = 0, exp_misses = 0;
  bit walk_seen = 0, ready_bad = 0;

  typedef struct packed {
    logic hit;
    logic fault;
    logic [FRAME_W-1:0] frame;
    logic [PROT_W-1:0] prot;
  } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  function automatic logic [FRAME_W-1:0] map_frame(logic [PAGE_W-1:0] p);
    return FRAME_W'(p * 13 + 5);
  endfunction
  function automatic logic is_fault(logic [PAGE_W-1:0] p);
    return p >= 20'h800;
  endfunction

  // stub walker: answers three cycles after walk_req rises
  int wcnt = 0;
  always @(posedge clk) begin
    walk_done <= 1'b0;
    if (walk_req && !walk_done) begin
      if (wcnt == 2) begin
        wcnt       <= 0;
        walk_done  <= 1'b1;
        walk_fault <= is_fault(walk_page);
        walk_frame <= map_frame(walk_page);
        walk_prot  <= walk_page[2:0];
      end else wcnt <= wcnt + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (walk_req) walk_seen = 1;
    if (walk_req && req_ready) ready_bad = 1;
    if (rsp_valid) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rsp_hit !== e.hit || rsp_fault !== e.fault || rsp_frame !== e.frame ||
          rsp_prot !== e.prot || walk_seen !== !e.hit) begin
        failures++;
        $display("FAIL %s: got hit=%0b fault=%0b frame=%h prot=%0d walked=%0b, exp hit=%0b fault=%0b frame=%h prot=%0d walked=%0b",
                 t, rsp_hit, rsp_fault, rsp_frame, rsp_prot, walk_seen,
                 e.hit, e.fault, e.frame, e.prot, !e.hit);
      end
      walk_seen = 0;
    end
  end

  task automatic lookup(input logic [PAGE_W-1:0] p, input logic hit, input string t);
    exp_t e;
    e.hit   = hit;
    e.fault = !hit && is_fault(p);
    e.frame = e.fault ? '0 : map_frame(p);
    e.prot  = e.fault ? '0 : p[2:0];
    if (hit) exp_hits++; else exp_misses++;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1;
    req_page  = p;
    @(negedge clk);
    req_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(req_ready === 1 && rsp_valid === 0 && walk_req === 0, "R1 idle outputs",
          {req_ready, rsp_valid, walk_req}, 3'b100);
    check(hit_count === 0 && miss_count === 0, "R1 counters", hit_count + miss_count, 0);

    lookup(20'h10, 0, "R4 first fill");
    lookup(20'h10, 1, "R2 hit after fill");
    for (int i = 1; i < 8; i++) lookup(20'h10 + i, 0, "R6 fill empty entry");
    lookup(20'h900, 0, "R5 fault");
    lookup(20'h900, 0, "R5 fault not stored");
    for (int i = 1; i < 8; i++) lookup(20'h10 + i, 1, "R2 hit full cache");
    lookup(20'h20, 0, "R7 evict entry 0");
    lookup(20'h11, 1, "R7 entry 1 kept");
    lookup(20'h10, 0, "R7 evicted page walks");
    lookup(20'h11, 0, "R7 pointer advanced to entry 1");
    lookup(20'h13, 1, "R7 entry 3 kept");

    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    lookup(20'h13, 0, "R8 miss after flush");
    lookup(20'h13, 1, "R8 refill hits");
    for (int i = 0; i < 7; i++) lookup(20'h30 + i, 0, "R6 refill after flush");
    lookup(20'h40, 0, "R7 evict at pointer 3");
    lookup(20'h31, 1, "R7 entry 2 kept");
    lookup(20'h32, 0, "R7 flush kept pointer");
    lookup(20'h13, 1, "R6 entry 0 kept");

    @(negedge clk);
    // R9
    check(hit_count === CNT_W'(exp_hits), "R9 hit_count", hit_count, exp_hits);
    check(miss_count === CNT_W'(exp_misses), "R9 miss_count", miss_count, exp_misses);
    // R3
    check(!ready_bad, "R3 ready low during walk", ready_bad, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule